// File: doc/BRIEF.md
# Per-Source Trigger-Selectable Interrupt Controller

This block gathers a vector of raw interrupt lines and turns them into one combined request line. Every source has its own choice of sensing: it can react to a rising edge, a falling edge, a high level or a low level. Four small registers set this up and show the state. One register holds the mask bits. One holds the pending bits, and a pending bit is cleared by writing a 1 to it. One selects edge or level sensing. One selects the active polarity. Each raw line first passes through a synchroniser. After that, detection is done per source.

Software reads and writes the registers in single cycles over a plain address/data port. Reads are combinational and always return the live value, so the mask can be updated by read-modify-write. The request output goes high when any source that is both pending and unmasked is present.

Several instances can be chained. A main instance takes the request lines of two subordinate instances: their normal requests on inputs 0 and 1, and their fast requests on inputs 30 and 31. After set-up the main instance unmasks only those four inputs, and the subordinate instances start fully masked.

Top module: `irq_trigger_ctrl`

## Requirements
- R1: While reset is held, every register reads 0 and `irq_o` is 0.
- R2: The mask register is at address 0. It reads back exactly what was last written. A 1 unmasks a source and a 0 masks it, and a masked source never raises `irq_o`.
- R3: The pending register is at address 1. Writing a 1 to an edge-mode bit clears that bit on the next clock edge. Writing a 0 leaves the bit unchanged.
- R4: An edge-mode source becomes pending on the third clock edge after its raw input makes the selected transition. The bit then stays set after the input returns, until software clears it.
- R5: The sensing register is at address 2. A bit value of 1 selects edge sensing and 0 selects level sensing.
- R6: The polarity register is at address 3. A bit value of 1 selects a rising edge or a high level. A bit value of 0 selects a falling edge or a low level.
- R7: A level-mode source shows pending for as long as its synchronised input sits at the active level, two edges behind the raw input. A clear write while that level lasts has no lasting effect.
- R8: `irq_o` is high exactly when at least one source is both pending and unmasked.
- R9: If a clear write to a bit lands in the same cycle that a new edge is detected on that bit, the bit remains set.
- R10: A write to one address leaves the contents of the other three registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_raw | input | NUM_SRC | Raw, asynchronous interrupt lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 mask, 1 pending, 2 sensing, 3 polarity) |
| wdata | input | NUM_SRC | Write data |
| rdata | output | NUM_SRC | Combinational read data for `addr` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with the default 32 sources and a two-stage synchroniser. At that size the four cascade positions 0, 1, 30 and 31 exist, so the main-instance mask pattern can be written and read back, and non-cascade sources can be shown to stay silent. The directed part covers a falling-edge source and a rising-edge source side by side, a low-level source under a clear write, and a clear that collides with a fresh edge. A long random phase then mixes mode switches and polarity flips in the middle of activity with a reference model of the timing.

// File: rtl/irqc_pkg.sv
// Shared definitions for the trigger-selectable interrupt controller.
// Assumes a two-bit word address selecting one of four registers.
package irqc_pkg;
    localparam int unsigned REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_ENABLE = 2'd0,
        REG_STATUS = 2'd1,
        REG_TYPE   = 2'd2,
        REG_POL    = 2'd3
    } irqc_reg_e;
endpackage

// File: rtl/irqc_sync.sv
// Multi-stage synchroniser for a vector of asynchronous lines.
// Assumes each bit is independent; no bus coherency is implied.
module irqc_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    // Shift raw lines through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_detect.sv
// Per-source trigger detection and pending state.
// Edge mode: sticky pending bit, set on inactive-to-active change, cleared by clr.
// A new edge wins over a clear in the same cycle.
// Level mode: pending mirrors the active level, registered once; clr is ignored.
// Assumes sync_in is already synchronous to clk.
module irqc_detect #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] sync_in,
    input  logic [NUM_SRC-1:0] edge_mode,
    input  logic [NUM_SRC-1:0] pol_high,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] hit_o
);
    logic [NUM_SRC-1:0] prev_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic act_now;
        logic act_prev;
        logic pend_q;

        assign act_now  = (sync_in[g] == pol_high[g]);
        assign act_prev = (prev_q[g]  == pol_high[g]);
        assign hit_o[g] = act_now & ~act_prev;

        // Update pending according to the selected sensing mode.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q    <= 1'b0;
                prev_q[g] <= 1'b0;
            end else begin
                prev_q[g] <= sync_in[g];
                if (edge_mode[g]) pend_q <= (pend_q & ~clr[g]) | hit_o[g];
                else              pend_q <= act_now;
            end
        end

        assign pend_o[g] = pend_q;
    end
endmodule

// File: rtl/irqc_regs.sv
// Configuration registers and read mux.
// Write-one-to-clear pulses go to the pending logic.
// Assumes single-cycle writes; reads are combinational on addr.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [NUM_SRC-1:0]    wdata,
    input  logic [NUM_SRC-1:0]    pend,
    output logic [NUM_SRC-1:0]    en_q,
    output logic [NUM_SRC-1:0]    typ_q,
    output logic [NUM_SRC-1:0]    pol_q,
    output logic [NUM_SRC-1:0]    clr,
    output logic [NUM_SRC-1:0]    rdata
);
    irqc_reg_e sel;
    assign sel = irqc_reg_e'(addr);

    // Hold mask, sensing and polarity; each changes only on its own address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            typ_q <= '0;
            pol_q <= '0;
        end else if (wr_en) begin
            if (sel == REG_ENABLE) en_q  <= wdata;
            if (sel == REG_TYPE)   typ_q <= wdata;
            if (sel == REG_POL)    pol_q <= wdata;
        end
    end

    // Clear pulses for the pending register.
    always_comb begin
        clr = '0;
        if (wr_en && sel == REG_STATUS) clr = wdata;
    end

    // Read mux.
    always_comb begin
        unique case (sel)
            REG_ENABLE: rdata = en_q;
            REG_STATUS: rdata = pend;
            REG_TYPE:   rdata = typ_q;
            REG_POL:    rdata = pol_q;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_trigger_ctrl.sv
// Top of the trigger-selectable interrupt controller.
// Raw lines are synchronised, then detected per source. Pending bits are
// masked and ORed into irq_o. Assumes SYNC_STAGES >= 2.
module irq_trigger_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC     = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    irq_raw,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [NUM_SRC-1:0]    wdata,
    output logic [NUM_SRC-1:0]    rdata,
    output logic                  irq_o
);
    logic [NUM_SRC-1:0] sync_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] hit_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] typ_q;
    logic [NUM_SRC-1:0] pol_q;
    logic [NUM_SRC-1:0] clr;

    irqc_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(irq_raw), .q(sync_q)
    );

    irqc_detect #(.NUM_SRC(NUM_SRC)) u_detect (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_q), .edge_mode(typ_q),
        .pol_high(pol_q), .clr(clr), .pend_o(pend_q), .hit_o(hit_q)
    );

    irqc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .pend(pend_q), .en_q(en_q), .typ_q(typ_q), .pol_q(pol_q),
        .clr(clr), .rdata(rdata)
    );

    // Combined request: any source both pending and unmasked.
    assign irq_o = |(pend_q & en_q);
endmodule

// File: rtl/irq_trigger_ctrl_chk.sv
// Assertion checker for irq_trigger_ctrl, attached with bind.
module irq_trigger_ctrl_chk
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [REG_ADDR_W-1:0] addr,
    input logic [NUM_SRC-1:0]    wdata,
    input logic [NUM_SRC-1:0]    en_q,
    input logic [NUM_SRC-1:0]    typ_q,
    input logic [NUM_SRC-1:0]    pol_q,
    input logic [NUM_SRC-1:0]    sync_q,
    input logic [NUM_SRC-1:0]    pend_q,
    input logic [NUM_SRC-1:0]    hit_q,
    input logic                  irq_o
);
    logic stat_wr;
    assign stat_wr = wr_en && (addr == REG_STATUS);

    a_r2_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_o);

    a_r8_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((pend_q & en_q) != '0));

    a_r4_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> (($past(pend_q) & $past(typ_q) & ~pend_q) == '0));

    a_r7_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~$past(typ_q) & (pend_q ^ ~($past(sync_q) ^ $past(pol_q)))) == '0));

    a_r3_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (($past(wdata) & $past(typ_q) & ~$past(hit_q) & pend_q) == '0));

    a_r9_clear_race: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (($past(hit_q) & $past(typ_q) & ~pend_q) == '0));
endmodule

bind irq_trigger_ctrl irq_trigger_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .en_q(en_q), .typ_q(typ_q), .pol_q(pol_q), .sync_q(sync_q),
    .pend_q(pend_q), .hit_q(hit_q), .irq_o(irq_o)
);

// File: tb/irq_trigger_ctrl_tb.sv
module irq_trigger_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_raw = '1;
    logic         wr_en = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic         irq_o;

    int checks = 0;
    int failures = 0;

    // Behavioural reference state
    logic [N-1:0] m_ff1 = '0, m_s = '0, m_sd = '0, m_pend = '0;
    logic [N-1:0] m_en = '0, m_typ = '0, m_pol = '0;

    irq_trigger_ctrl #(.NUM_SRC(N), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model update on every clock, then compare a quarter period later.
    always @(posedge clk) begin
        logic [N-1:0] np;
        bit a, ad;
        if (!rst_n) begin
            m_ff1 = '0; m_s = '0; m_sd = '0; m_pend = '0;
            m_en = '0; m_typ = '0; m_pol = '0;
        end else begin
            np = m_pend;
            for (int i = 0; i < N; i++) begin
                a  = (m_s[i] == m_pol[i]);
                ad = (m_sd[i] == m_pol[i]);
                if (m_typ[i]) begin
                    if (wr_en && addr == 2'd1 && wdata[i]) np[i] = 1'b0;
                    if (a && !ad) np[i] = 1'b1;
                end else begin
                    np[i] = a;
                end
            end
            m_pend = np;
            m_sd = m_s; m_s = m_ff1; m_ff1 = irq_raw;
            if (wr_en) begin
                case (addr)
                    2'd0: m_en  = wdata;
                    2'd2: m_typ = wdata;
                    2'd3: m_pol = wdata;
                    default: ;
                endcase
            end
        end
        #(CLK_PERIOD/4);
        chk("R8 model irq", {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, |(m_pend & m_en)});
        case (addr)
            2'd0: chk("R2 model mask", rdata, m_en);
            2'd1: chk("R4 model pending", rdata, m_pend);
            2'd2: chk("R5 model sensing", rdata, m_typ);
            default: chk("R6 model polarity", rdata, m_pol);
        endcase
    end

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [N-1:0] exp, input string tag);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic irq_is(input logic exp, input string tag);
        chk(tag, {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, exp});
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_n(3);
        // R1: reset contents
        rd(2'd0, '0, "R1 mask in reset");
        rd(2'd1, '0, "R1 pending in reset");
        rd(2'd2, '0, "R1 sensing in reset");
        rd(2'd3, '0, "R1 polarity in reset");
        irq_is(1'b0, "R1 irq in reset");
        rst_n = 1'b1;
        wait_n(3);
        rd(2'd1, '0, "R7 inactive low-level sources");

        // Main-instance cascade mask pattern
        wr(2'd0, 32'hC000_0003);
        rd(2'd0, 32'hC000_0003, "R2 mask readback");
        wr(2'd2, 32'h0000_00F0);
        wr(2'd3, 32'h0000_0050);
        rd(2'd2, 32'h0000_00F0, "R5 sensing readback");
        rd(2'd3, 32'h0000_0050, "R6 polarity readback");
        rd(2'd0, 32'hC000_0003, "R10 mask untouched");
        rd(2'd1, '0, "R5 no event yet");

        // Falling on rising source 4 and falling source 5
        irq_raw[4] = 1'b0; irq_raw[5] = 1'b0;
        wait_n(2);
        rd(2'd1, '0, "R4 not yet pending after two edges");
        wait_n(1);
        rd(2'd1, 32'h0000_0020, "R6 falling edge on third edge");
        irq_is(1'b0, "R2 masked source quiet");
        irq_raw[4] = 1'b1; irq_raw[5] = 1'b1;
        wait_n(4);
        rd(2'd1, 32'h0000_0030, "R4 rising edge and sticky");

        wr(2'd0, 32'hC000_0013);
        #1 irq_is(1'b1, "R8 unmasked pending drives irq");
        wr(2'd1, 32'h0000_0000);
        rd(2'd1, 32'h0000_0030, "R3 zero write no effect");
        wr(2'd1, 32'h0000_0010);
        rd(2'd1, 32'h0000_0020, "R3 one write clears");
        irq_is(1'b0, "R8 irq drops after clear");
        rd(2'd0, 32'hC000_0013, "R10 mask after status write");

        // Level-low cascade source 1
        irq_raw[1] = 1'b0;
        wait_n(4);
        rd(2'd1, 32'h0000_0022, "R7 low level pending");
        irq_is(1'b1, "R8 level source irq");
        wr(2'd1, 32'h0000_0002);
        wait_n(1);
        rd(2'd1, 32'h0000_0022, "R7 clear ignored while active");
        irq_raw[1] = 1'b1;
        wait_n(4);
        rd(2'd1, 32'h0000_0020, "R7 level released");
        irq_is(1'b0, "R8 irq low again");

        // Clear colliding with a fresh edge on source 6
        irq_raw[6] = 1'b0;
        wait_n(4);
        irq_raw[6] = 1'b1;
        wait_n(2);
        wr_en = 1'b1; addr = 2'd1; wdata = 32'h0000_0060;
        @(negedge clk);
        wr_en = 1'b0;
        rd(2'd1, 32'h0000_0040, "R9 new edge survives clear");

        wr(2'd0, 32'h0000_0000);
        wr(2'd3, 32'h0000_0000);
        #1 irq_is(1'b0, "R2 all masked");
        rd(2'd2, 32'h0000_00F0, "R10 sensing after other writes");

        // Random phase, checked by the model
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if ($urandom_range(0, 3) == 0) irq_raw = irq_raw ^ (32'h1 << $urandom_range(0, N-1));
            wr_en = ($urandom_range(0, 4) == 0);
            addr  = 2'($urandom_range(0, 3));
            wdata = $urandom;
        end
        @(negedge clk);
        wr_en = 1'b0;
        wait_n(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule